// File: doc/BRIEF.md
# Power-Gated Register Proxy Engine

This block lets a host reach registers that live in power-gated domains without first waking those domains itself. The host sees a small window of registers on a plain memory-mapped bus. To start an access it writes one control word. That word names a target offset, the direction of the access and the power domain that owns the target, and it has a start bit set. The engine raises a wake request towards the chosen domain, or towards all three domains. It waits until every requested domain acknowledges, then performs exactly one 32-bit transfer on a back-end register port. When the transfer is done it drops the wake request and clears the start bit.

Write data is staged in a data register before the launch. Read results land in that same data register, so the host polls the start bit and then reads the data. A wider value is moved as a series of separate launches, one per dword. If a domain never acknowledges, a programmable wait limit ends the attempt. The engine then records a sticky timeout flag and the back-end port stays untouched.

Top module: `pgreg_proxy`

## Requirements
- R1: The host register window has four registers. The data register is at 0xF00 and the control register at 0xF04. The status register is at 0xF08; its bit 0 is the sticky timeout flag. The wait-limit register is at 0xF0C. Any other address reads 0. After reset every register reads 0 except the wait limit, which reads 64, and no wake request or back-end request is active.
- R2: The control word has the start bit at bit 31, the domain code at bits 29:28, the operation bit at bit 24 (0 = write, 1 = read) and the target offset at bits 23:0. All other bits read 0. A read of the control register returns the live start bit together with the last accepted fields.
- R3: A control write with bit 31 set, accepted while the engine is idle, sets the start bit and latches the fields. In the same cycle it captures the current data register contents as the write payload.
- R4: From the cycle after a launch until completion, wake_req carries the domain mask: code 0 → bit 0, code 1 → bit 1, code 2 → bit 2, code 3 → all three bits. Otherwise wake_req is 0.
- R5: The cycle after every requested acknowledge is seen, be_req rises. be_addr is the offset with bits 1:0 forced to 0. be_we is 1 for the write operation, and be_wdata is the captured payload.
- R6: When be_ack is seen during a back-end access, the next cycle has the start bit clear, wake_req at 0 and be_req at 0. For a read operation, the data register then holds be_rdata.
- R7: While the start bit is set, host writes to the control register and to the data register are ignored.
- R8: Suppose the acknowledges are incomplete for as many consecutive waiting cycles as the wait limit, with a limit of 0 acting as 1. The engine then sets the sticky timeout flag and clears the start bit, and be_req never rises for that launch.
- R9: Writing 1 to status bit 0 clears the timeout flag. If a timeout occurs in the same cycle, the flag ends up set.
- R10: Each successful launch causes exactly one back-end handshake. A 64-bit value is read as two launches, at the offset and at the offset plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| wake_req | output | 3 | Per-domain wake request (blitter, render, media) |
| wake_ack | input | 3 | Per-domain wake acknowledge |
| be_req | output | 1 | Back-end access request, held until be_ack |
| be_we | output | 1 | Back-end write enable |
| be_addr | output | 24 | Back-end dword-aligned address |
| be_wdata | output | 32 | Back-end write data |
| be_rdata | input | 32 | Back-end read data, valid with be_ack |
| be_ack | input | 1 | Back-end completion |

## Verification
Two collisions can fall in the same cycle. The most delicate one is a wait-limit expiry meeting a host write-1-to-clear of the timeout flag. The bench provokes it by timing the status write so that it lands on the exact edge where the wait budget runs out, and the flag must remain set afterwards. The second collision is a host control or data write that arrives while an access is in flight. It is provoked with a slow-waking domain, and the bench judges it by reading back the unchanged fields and payload after completion. A behavioural cycle model checks wake and back-end outputs and every readback on every clock.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  localparam int OFF_DATA  = 'hF00;
  localparam int OFF_CTRL  = 'hF04;
  localparam int OFF_STAT  = 'hF08;
  localparam int OFF_LIMIT = 'hF0C;

  localparam int START_BIT = 31;
  localparam int OP_BIT    = 24;
  localparam int TGT_W     = 24;
  localparam int NDOM      = 3;

  typedef enum logic [1:0] {
    DOM_BLT = 2'd0,
    DOM_RND = 2'd1,
    DOM_MED = 2'd2,
    DOM_ALL = 2'd3
  } dom_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_XFER = 2'd2
  } st_e;

  typedef struct packed {
    dom_e             dom;
    logic             rd;
    logic [TGT_W-1:0] off;
  } ctl_t;

  function automatic logic [NDOM-1:0] dom_mask(input dom_e d);
    if (d == DOM_ALL) return '1;
    return NDOM'(1) << d;
  endfunction

  function automatic ctl_t ctl_decode(input logic [31:0] w);
    ctl_t c;
    c.dom = dom_e'(w[29:28]);
    c.rd  = w[OP_BIT];
    c.off = w[TGT_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] ctl_encode(input logic go, input ctl_t c);
    return {go, 1'b0, c.dom, 3'b000, c.rd, c.off};
  endfunction

  function automatic logic [TGT_W-1:0] dword_addr(input logic [TGT_W-1:0] off);
    return {off[TGT_W-1:2], 2'b00};
  endfunction

endpackage

// File: rtl/pgreg_hostif.sv
module pgreg_hostif
  import pgreg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 16,
  parameter int LIMIT_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [31:0]       rd_value,
  input  logic              tmo_set,
  output logic              launch,
  output ctl_t              fld,
  output logic [31:0]       wr_hold,
  output logic [CNT_W-1:0]  limit,
  output logic              tmo_flag
);

  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFF_LIMIT);

  logic        hit_data, hit_ctrl, hit_stat, hit_limit;
  logic        ctrl_take, data_take, tmo_clear;
  logic [31:0] data_q;
  logic        unused_bits;

  assign hit_data  = host_we && (host_addr == A_DATA);
  assign hit_ctrl  = host_we && (host_addr == A_CTRL);
  assign hit_stat  = host_we && (host_addr == A_STAT);
  assign hit_limit = host_we && (host_addr == A_LIMIT);

  assign ctrl_take = hit_ctrl && !busy;
  assign data_take = hit_data && !busy;
  assign launch    = ctrl_take && host_wdata[START_BIT];
  assign tmo_clear = hit_stat && host_wdata[0];

  assign unused_bits = ^host_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      wr_hold  <= '0;
      fld      <= '0;
      tmo_flag <= 1'b0;
      limit    <= CNT_W'(LIMIT_RST);
    end else begin
      if (rd_load)        data_q <= rd_value;
      else if (data_take) data_q <= host_wdata;
      if (ctrl_take) fld <= ctl_decode(host_wdata);
      if (launch)    wr_hold <= data_q;
      if (tmo_set)        tmo_flag <= 1'b1;
      else if (tmo_clear) tmo_flag <= 1'b0;
      if (hit_limit) limit <= host_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    if (host_addr == A_DATA)       host_rdata = data_q;
    else if (host_addr == A_CTRL)  host_rdata = ctl_encode(busy, fld);
    else if (host_addr == A_STAT)  host_rdata = {31'd0, tmo_flag};
    else if (host_addr == A_LIMIT) host_rdata = 32'(limit);
    else                           host_rdata = '0;
  end

endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
  import pgreg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  dom_e             dom,
  input  logic [CNT_W-1:0] limit,
  input  logic [NDOM-1:0]  wake_ack,
  input  logic             be_ack,
  output st_e              st,
  output logic [NDOM-1:0]  wake_req,
  output logic             busy,
  output logic             acks_ok,
  output logic             fin_tmo
);

  logic [CNT_W-1:0] cnt;
  logic [NDOM-1:0]  mask;

  function automatic logic budget_spent(input logic [CNT_W-1:0] c,
                                        input logic [CNT_W-1:0] lim);
    return ({1'b0, c} + (CNT_W+1)'(1)) >= {1'b0, lim};
  endfunction

  assign mask     = dom_mask(dom);
  assign busy     = (st != ST_IDLE);
  assign wake_req = busy ? mask : '0;
  assign acks_ok  = ((wake_ack & mask) == mask);
  assign fin_tmo  = (st == ST_WAKE) && !acks_ok && budget_spent(cnt, limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch) begin
          st  <= ST_WAKE;
          cnt <= '0;
        end
        ST_WAKE: begin
          if (acks_ok)      st <= ST_XFER;
          else if (fin_tmo) st <= ST_IDLE;
          else              cnt <= cnt + CNT_W'(1);
        end
        ST_XFER: if (be_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgreg_xfer.sv
module pgreg_xfer
  import pgreg_pkg::*;
(
  input  st_e              st,
  input  ctl_t             fld,
  input  logic [31:0]      wr_hold,
  input  logic [31:0]      be_rdata,
  input  logic             be_ack,
  output logic             be_req,
  output logic             be_we,
  output logic [TGT_W-1:0] be_addr,
  output logic [31:0]      be_wdata,
  output logic             rd_load,
  output logic [31:0]      rd_value
);

  assign be_req   = (st == ST_XFER);
  assign be_we    = be_req && !fld.rd;
  assign be_addr  = dword_addr(fld.off);
  assign be_wdata = wr_hold;
  assign rd_load  = be_req && be_ack && fld.rd;
  assign rd_value = be_rdata;

endmodule

// File: rtl/pgreg_proxy.sv
module pgreg_proxy
  import pgreg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 16,
  parameter int LIMIT_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic [2:0]        wake_req,
  input  logic [2:0]        wake_ack,
  output logic              be_req,
  output logic              be_we,
  output logic [23:0]       be_addr,
  output logic [31:0]       be_wdata,
  input  logic [31:0]       be_rdata,
  input  logic              be_ack
);

  logic             launch, busy, acks_ok, fin_tmo, rd_load, tmo_flag;
  ctl_t             fld;
  logic [31:0]      wr_hold, rd_value;
  logic [CNT_W-1:0] limit;
  st_e              st;

  pgreg_hostif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LIMIT_RST(LIMIT_RST)) u_regs (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .busy, .rd_load, .rd_value, .tmo_set(fin_tmo),
    .launch, .fld, .wr_hold, .limit, .tmo_flag
  );

  pgreg_seq #(.CNT_W(CNT_W)) u_seq (
    .clk, .rst_n, .launch, .dom(fld.dom), .limit, .wake_ack, .be_ack,
    .st, .wake_req, .busy, .acks_ok, .fin_tmo
  );

  pgreg_xfer u_xfer (
    .st, .fld, .wr_hold, .be_rdata, .be_ack,
    .be_req, .be_we, .be_addr, .be_wdata, .rd_load, .rd_value
  );

endmodule

// File: rtl/pgreg_proxy_chk.sv
module pgreg_proxy_chk
  import pgreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [2:0]        wake_req,
  input logic [2:0]        wake_ack,
  input logic              be_req,
  input logic              be_ack,
  input logic              busy,
  input logic              launch,
  input logic              fin_tmo,
  input logic              tmo_flag,
  input ctl_t              fld
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  assert_launch_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && (wake_req != 3'b000)));

  assert_req_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(wake_req) || (wake_req == 3'b111)));

  assert_acked_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(be_req) |-> $past(((wake_ack & wake_req) == wake_req) && (wake_req != 3'b000)));

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_ack) |=> (!busy && (wake_req == 3'b000) && !be_req));

  assert_busy_ctrl_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && (host_addr == A_CTRL)) |=> $stable(fld));

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_tmo |=> (tmo_flag && !be_req && !busy));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_tmo && host_we && (host_addr == A_STAT)) |=> tmo_flag);

endmodule

bind pgreg_proxy pgreg_proxy_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .host_we, .host_addr, .wake_req, .wake_ack, .be_req, .be_ack,
  .busy, .launch, .fin_tmo, .tmo_flag, .fld
);

// File: tb/pgreg_proxy_test.sv
module pgreg_proxy_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [11:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [2:0]  wake_req;
  logic [2:0]  wake_ack;
  logic        be_req, be_we, be_ack;
  logic [23:0] be_addr;
  logic [31:0] be_wdata, be_rdata;

  always #4 clk = ~clk;

  pgreg_proxy uut (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .wake_req, .wake_ack, .be_req, .be_we, .be_addr, .be_wdata, .be_rdata, .be_ack
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // ---------------- environment: domains and back-end memory ----------------
  int          wlat[3];
  int          wcnt[3];
  int          be_lat = 1;
  int          be_cnt = 0;
  int          be_hs  = 0;
  logic [31:0] mem [256];

  always @(negedge clk) begin
    for (int d = 0; d < 3; d++) begin
      if (wake_req[d]) begin
        wcnt[d]++;
        wake_ack[d] = (wcnt[d] > wlat[d]);
      end else begin
        wcnt[d] = 0;
        wake_ack[d] = 1'b0;
      end
    end
    if (be_req) begin
      be_cnt++;
      be_ack = (be_cnt > be_lat);
    end else begin
      be_cnt = 0;
      be_ack = 1'b0;
    end
    be_rdata = mem[be_addr[9:2]];
  end

  always @(posedge clk) begin
    if (rst_n && be_req && be_ack) begin
      if (be_we) mem[be_addr[9:2]] = be_wdata;
      be_hs++;
    end
  end

  // ---------------- behavioural reference model ----------------
  int          m_ph;
  int          m_waited;
  int          m_lim;
  bit [1:0]    m_dom;
  bit          m_rd;
  bit [23:0]   m_off;
  bit [31:0]   m_data, m_hold;
  bit          m_tmo;

  function automatic bit [2:0] need_of(input bit [1:0] d);
    case (d)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b111;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_waited = 0; m_lim = 64; m_dom = 0; m_rd = 0; m_off = 0;
      m_data = 0; m_hold = 0; m_tmo = 0;
    end else begin
      automatic bit was_busy = (m_ph != 0);
      automatic bit [31:0] old_data = m_data;
      automatic bit tmo_now = 0;
      automatic int nxt = m_ph;
      if (m_ph == 1) begin
        if ((wake_ack & need_of(m_dom)) == need_of(m_dom)) nxt = 2;
        else if (m_waited + 1 >= m_lim) begin tmo_now = 1; nxt = 0; end
        else m_waited++;
      end else if (m_ph == 2) begin
        if (be_ack) begin
          if (m_rd) m_data = be_rdata;
          nxt = 0;
        end
      end
      if (host_we) begin
        if (host_addr == 12'hF00 && !was_busy) m_data = host_wdata;
        if (host_addr == 12'hF04 && !was_busy) begin
          m_dom = host_wdata[29:28]; m_rd = host_wdata[24]; m_off = host_wdata[23:0];
          if (host_wdata[31]) begin nxt = 1; m_waited = 0; m_hold = old_data; end
        end
        if (host_addr == 12'hF0C) m_lim = int'(host_wdata[15:0]);
      end
      if (tmo_now) m_tmo = 1;
      else if (host_we && host_addr == 12'hF08 && host_wdata[0]) m_tmo = 0;
      m_ph = nxt;
    end
  end

  function automatic bit [31:0] model_read(input logic [11:0] a);
    case (a)
      12'hF00: return m_data;
      12'hF04: return {m_ph != 0, 1'b0, m_dom, 3'b000, m_rd, m_off};
      12'hF08: return {31'd0, m_tmo};
      12'hF0C: return 32'(m_lim);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R4 wake_req vs model", {29'd0, wake_req}, {29'd0, (m_ph != 0) ? need_of(m_dom) : 3'b000});
      chk("R5 be_req vs model", {31'd0, be_req}, {31'd0, m_ph == 2});
      if (m_ph == 2) begin
        chk("R5 be_we vs model", {31'd0, be_we}, {31'd0, !m_rd});
        chk("R5 be_addr vs model", {8'd0, be_addr}, {8'd0, m_off[23:2], 2'b00});
        if (!m_rd) chk("R5 be_wdata vs model", be_wdata, m_hold);
      end
      chk("R1 R2 R6 R9 readback vs model", host_rdata, model_read(host_addr));
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_addr = a;
    #1;
    chk(tag, host_rdata, exp);
  endtask

  task automatic go(input logic [1:0] dom, input logic op, input logic [23:0] off);
    wr(12'hF04, {1'b1, 1'b0, dom, 3'b000, op, off});
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin
      @(negedge clk);
      host_addr = 12'hF04;
      #1;
      n++;
    end while (host_rdata[31] && n < 3000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hs0;
    wlat[0] = 0; wlat[1] = 2; wlat[2] = 3;
    wcnt[0] = 0; wcnt[1] = 0; wcnt[2] = 0;
    wake_ack = 3'b000; be_ack = 1'b0; be_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0203;
    rst_n = 1'b0; host_we = 1'b0; host_addr = 12'h000; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'hF00, 32'h0, "R1 data reset");
    rd(12'hF04, 32'h0, "R1 ctrl reset");
    rd(12'hF08, 32'h0, "R1 status reset");
    rd(12'hF0C, 32'd64, "R1 limit reset");
    rd(12'h100, 32'h0, "R1 unmapped reads zero");
    chk("R1 no requests after reset", {28'd0, wake_req, be_req}, 32'h0);

    // R3 R5 write through render domain
    wr(12'hF00, 32'hDEAD_BEEF);
    hs0 = be_hs;
    go(2'd1, 1'b0, 24'h000040);
    wait_idle();
    chk("R3 write landed", mem[8'h10], 32'hDEAD_BEEF);
    rd(12'hF04, 32'h1000_0040, "R2 ctrl readback after write");
    chk("R10 one handshake per write", be_hs - hs0, 1);

    // R6 read through media domain
    go(2'd2, 1'b1, 24'h000044);
    wait_idle();
    rd(12'hF00, mem[8'h11], "R6 read result in data");

    // R10 64-bit read as two launches, all domains
    hs0 = be_hs;
    go(2'd3, 1'b1, 24'h000080);
    wait_idle();
    rd(12'hF00, mem[8'h20], "R10 low dword");
    go(2'd3, 1'b1, 24'h000084);
    wait_idle();
    rd(12'hF00, mem[8'h21], "R10 high dword");
    chk("R10 two handshakes", be_hs - hs0, 2);

    // R5 low offset bits ignored on back end, blitter domain
    go(2'd0, 1'b1, 24'h00004B);
    wait_idle();
    rd(12'hF00, mem[8'h12], "R5 dword alignment");
    rd(12'hF04, 32'h0100_004B, "R2 offset bits kept in readback");

    // R7 writes during an access are ignored
    wlat[1] = 10;
    wr(12'hF00, 32'hCAFE_F00D);
    hs0 = be_hs;
    go(2'd1, 1'b0, 24'h00000C);
    wr(12'hF04, 32'h8100_0200);
    wr(12'hF00, 32'h1234_5678);
    wait_idle();
    chk("R7 payload kept", mem[8'h03], 32'hCAFE_F00D);
    chk("R7 ignored launch not run", mem[8'h80], 32'h1000_0000 + 32'h80 * 32'h0001_0203);
    rd(12'hF00, 32'hCAFE_F00D, "R7 data write ignored");
    rd(12'hF04, 32'h1000_000C, "R7 ctrl fields kept");
    chk("R7 single handshake", be_hs - hs0, 1);
    wlat[1] = 2;

    // R8 timeout on a media domain that never wakes
    wr(12'hF0C, 32'd5);
    wlat[2] = 100000;
    hs0 = be_hs;
    go(2'd2, 1'b1, 24'h000010);
    wait_idle();
    rd(12'hF08, 32'h1, "R8 sticky timeout set");
    chk("R8 no back-end access", be_hs - hs0, 0);
    rd(12'hF00, 32'hCAFE_F00D, "R8 data untouched");

    // R9 plain clear
    wr(12'hF08, 32'h1);
    rd(12'hF08, 32'h0, "R9 clear by write one");

    // R9 clear collides with timeout on the same edge
    go(2'd2, 1'b1, 24'h000010);
    repeat (4) @(negedge clk);
    host_we = 1'b1; host_addr = 12'hF08; host_wdata = 32'h1;
    @(negedge clk);
    host_we = 1'b0;
    rd(12'hF08, 32'h1, "R9 set wins over clear");
    wr(12'hF08, 32'h1);

    // R8 limit zero behaves as one
    wr(12'hF0C, 32'd0);
    go(2'd2, 1'b0, 24'h000020);
    wait_idle();
    rd(12'hF08, 32'h1, "R8 limit zero times out");
    wr(12'hF08, 32'h1);

    // recovery with a slow back end
    wr(12'hF0C, 32'd64);
    wlat[2] = 3;
    be_lat = 4;
    go(2'd3, 1'b1, 24'h000000);
    wait_idle();
    rd(12'hF00, mem[8'h00], "R6 read after recovery");
    rd(12'hF08, 32'h0, "R9 status clear after recovery");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule